// File: doc/BRIEF.md
# Four-Channel Prioritized DMA Engine

The block holds four independent DMA channels that share one transfer port. Software programs each channel through a small write-only register interface. Each channel has a programmed source address, a destination address, a unit count and a control word. When the control word's enable bit goes from clear to set, the channel copies its programmed source, destination and count into working registers. From then on it runs from those copies, so later writes to the programmed values do not touch a transfer that is in progress.

A channel becomes armed in one of three ways: at once when it is enabled, on a vertical-blank pulse, or on a horizontal-blank pulse. A fourth timing code is decoded but never arms the channel. Armed channels compete for the transfer port through a fixed-priority arbiter, and the lowest channel index wins. Each accepted request on the port moves one unit (a read at the source, then a write at the destination). After each unit the winning channel steps its addresses and its count. While a channel started with the immediate timing code is armed, the block raises a CPU stall output.

The transfer port is valid/ready. The block raises `xfer_valid` with the channel, addresses, size and last flag. A unit is moved on a clock edge where both `xfer_valid` and `xfer_ready` are high. While `xfer_valid` is high and `xfer_ready` is low, the request and its payload stay unchanged, even if a higher-priority channel becomes armed in the meantime. The consumer may hold `xfer_ready` low for as long as it needs.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset no request is presented, `cpu_stall` is low and every bit of `chan_en` is clear.
- R2: When control bit 0 (enable) goes from 0 to 1, the channel latches its programmed source (select 0), destination (select 1) and count (select 2) into working copies. Writes to those selects while the channel runs leave the addresses and the number of remaining units of the running transfer unchanged.
- R3: Timing code 0 (control bits 2:1) arms the channel on the enable write. `cpu_stall` is high while any channel armed with code 0 is armed.
- R4: Timing code 1 arms an enabled, idle channel on `vblank_pulse`, and code 2 does so on `hblank_pulse`. A pulse of the other kind, any pulse while code 3 is set, and any pulse to a channel whose enable bit is clear have no effect. Channels armed by a blanking pulse never raise `cpu_stall`.
- R5: Source adjust (control bits 4:3) and destination adjust (bits 6:5) work as follows after each unit: 0 adds the step, 1 subtracts it, 2 holds the address, and 3 adds like 0. The step is 4 bytes when control bit 7 is set and 2 bytes otherwise, and `xfer_wide` reports that bit.
- R6: Channels 0 to 2 keep only the low 14 bits of a count write, and channel 3 keeps 16 bits. A count of zero runs the largest count that width can hold (16383 or 65535 units).
- R7: After the last unit the channel's enable bit clears by itself and the channel presents no further requests.
- R8: When several channels are armed, the lowest-numbered one is granted, and only one unit moves per accepted cycle.
- R9: While `xfer_valid` is high and `xfer_ready` is low, the request stays up with the channel, the addresses, the size and the last flag unchanged. Exactly one unit is consumed per accepted handshake.
- R10: Writing the control word with enable clear disarms the channel at once, and it presents no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_sel | input | 2 | 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Write data |
| hblank_pulse | input | 1 | One-cycle horizontal-blank event |
| vblank_pulse | input | 1 | One-cycle vertical-blank event |
| xfer_valid | output | 1 | Unit request present |
| xfer_ready | input | 1 | Consumer accepts the unit |
| xfer_ch | output | 2 | Granted channel |
| xfer_src | output | 32 | Read address of the unit |
| xfer_dst | output | 32 | Write address of the unit |
| xfer_wide | output | 1 | 1 = 4-byte unit, 0 = 2-byte unit |
| xfer_last | output | 1 | Unit is the channel's final one |
| cpu_stall | output | 1 | An immediate-timed channel is armed |
| chan_en | output | 4 | Enable bit of each channel |

## Verification
The bench goes after these corner cases:
- The zero count on both a 14-bit channel and the 16-bit channel, each run to completion. A design that treated zero as "none" would move nothing. One that used a single width would stop at the wrong count.
- A count write of 0x4005 on a 14-bit channel. A design without truncation would run thousands of units instead of 5.
- A source rewrite and a higher-priority arm while the port is held off. This exposes a design that relatches its working copies, or that switches the granted channel before the handshake.
- Mismatched, special and repeated blanking pulses, and every adjust code in both step sizes. Every unit's addresses are compared with arithmetic expectations, so a wrong sign or step shows up on the first unit.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ADJ_INC     = 2'd0,
    ADJ_DEC     = 2'd1,
    ADJ_FIX     = 2'd2,
    ADJ_INC_RLD = 2'd3
  } adj_e;

  typedef enum logic [1:0] {
    TM_NOW     = 2'd0,
    TM_VBL     = 2'd1,
    TM_HBL     = 2'd2,
    TM_SPECIAL = 2'd3
  } timing_e;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  typedef struct packed {
    logic    wide;
    adj_e    dst_adj;
    adj_e    src_adj;
    timing_e timing;
    logic    en;
  } ctrl_t;
endpackage

// File: rtl/dma4_addr_step.sv
module dma4_addr_step
  import dma4_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  adj_e              adj,
  input  logic              wide,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] delta;

  assign delta = wide ? ADDR_W'(4) : ADDR_W'(2);

  always_comb begin
    unique case (adj)
      ADJ_INC, ADJ_INC_RLD: nxt = addr + delta;
      ADJ_DEC:              nxt = addr - delta;
      default:              nxt = addr;
    endcase
  end
endmodule

// File: rtl/dma4_channel.sv
module dma4_channel
  import dma4_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              hblank,
  input  logic              vblank,
  input  logic              step,
  output logic              armed,
  output logic              enabled,
  output logic              stall_req,
  output logic              wide,
  output logic              last,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst
);
  logic [ADDR_W-1:0] prog_src, prog_dst;
  logic [CNT_W-1:0]  prog_cnt;
  ctrl_t             ctrl_q, ctrl_new;
  logic [ADDR_W-1:0] work_src, work_dst, nxt_src, nxt_dst;
  logic [CNT_W-1:0]  work_cnt;
  logic              armed_q;
  logic              blank_hit;
  logic              ctrl_wr;

  assign ctrl_new = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);

  dma4_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .addr(work_src), .adj(ctrl_q.src_adj), .wide(ctrl_q.wide), .nxt(nxt_src)
  );
  dma4_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .addr(work_dst), .adj(ctrl_q.dst_adj), .wide(ctrl_q.wide), .nxt(nxt_dst)
  );

  always_comb begin
    blank_hit = 1'b0;
    if (ctrl_q.en && !armed_q) begin
      unique case (ctrl_q.timing)
        TM_VBL:  blank_hit = vblank;
        TM_HBL:  blank_hit = hblank;
        default: blank_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_src <= '0;
      prog_dst <= '0;
      prog_cnt <= '0;
      ctrl_q   <= '0;
      work_src <= '0;
      work_dst <= '0;
      work_cnt <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (step && armed_q) begin
        work_src <= nxt_src;
        work_dst <= nxt_dst;
        if (last) begin
          ctrl_q.en <= 1'b0;
          armed_q   <= 1'b0;
        end else begin
          work_cnt <= work_cnt - 1'b1;
        end
      end
      if (blank_hit) armed_q <= 1'b1;
      if (wr_en) begin
        unique case (wr_sel)
          SEL_SRC: prog_src <= wr_data[ADDR_W-1:0];
          SEL_DST: prog_dst <= wr_data[ADDR_W-1:0];
          SEL_CNT: prog_cnt <= wr_data[CNT_W-1:0];
          default: begin
            ctrl_q <= ctrl_new;
            if (ctrl_new.en && !ctrl_q.en) begin
              work_src <= prog_src;
              work_dst <= prog_dst;
              work_cnt <= (prog_cnt == '0) ? '1 : prog_cnt;
              armed_q  <= (ctrl_new.timing == TM_NOW);
            end else if (!ctrl_new.en) begin
              armed_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign armed     = armed_q;
  assign enabled   = ctrl_q.en;
  assign stall_req = armed_q && (ctrl_q.timing == TM_NOW);
  assign wide      = ctrl_q.wide;
  assign last      = (work_cnt == CNT_W'(1));
  assign cur_src   = work_src;
  assign cur_dst   = work_dst;

  // R4
  armed_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ctrl_q.en);

  // R6
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (work_cnt != '0));

  // R2
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ctrl_wr) |=> ($stable(work_src) && $stable(work_dst) && $stable(work_cnt)));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && armed_q && last && !wr_en) |=> (!ctrl_q.en && !armed_q));
endmodule

// File: rtl/dma4_arbiter.sv
module dma4_arbiter #(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  armed,
  input  logic            ready,
  output logic            valid,
  output logic [CH_W-1:0] grant
);
  logic [CH_W-1:0] pick, hold_ch_q;
  logic            hold_q;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (armed[i]) pick = CH_W'(i);
    end
  end

  assign grant = hold_q ? hold_ch_q : pick;
  assign valid = hold_q ? armed[hold_ch_q] : (|armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_ch_q <= '0;
    end else if (valid && !ready) begin
      hold_q    <= 1'b1;
      hold_ch_q <= grant;
    end else begin
      hold_q <= 1'b0;
    end
  end

  // R8
  grant_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> armed[grant]);

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !hold_q) |-> ((armed & ((NCH'(1) << grant) - NCH'(1))) == '0));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W_STD  = 14,
  parameter int CNT_W_LAST = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [$clog2(NCH)-1:0]  reg_ch,
  input  logic [1:0]              reg_sel,
  input  logic [REG_W-1:0]        reg_wdata,
  input  logic                    hblank_pulse,
  input  logic                    vblank_pulse,
  output logic                    xfer_valid,
  input  logic                    xfer_ready,
  output logic [$clog2(NCH)-1:0]  xfer_ch,
  output logic [ADDR_W-1:0]       xfer_src,
  output logic [ADDR_W-1:0]       xfer_dst,
  output logic                    xfer_wide,
  output logic                    xfer_last,
  output logic                    cpu_stall,
  output logic [NCH-1:0]          chan_en
);
  localparam int CH_W = $clog2(NCH);

  logic [NCH-1:0]             armed_w, stall_w, wide_w, last_w;
  logic [NCH-1:0][ADDR_W-1:0] src_w, dst_w;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int CW = (i == NCH - 1) ? CNT_W_LAST : CNT_W_STD;
    logic wr_hit, step_hit;
    assign wr_hit   = reg_we && (reg_ch == CH_W'(i));
    assign step_hit = xfer_valid && xfer_ready && (xfer_ch == CH_W'(i));

    dma4_channel #(.ADDR_W(ADDR_W), .CNT_W(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_hit),
      .wr_sel    (sel_e'(reg_sel)),
      .wr_data   (reg_wdata),
      .hblank    (hblank_pulse),
      .vblank    (vblank_pulse),
      .step      (step_hit),
      .armed     (armed_w[i]),
      .enabled   (chan_en[i]),
      .stall_req (stall_w[i]),
      .wide      (wide_w[i]),
      .last      (last_w[i]),
      .cur_src   (src_w[i]),
      .cur_dst   (dst_w[i])
    );
  end

  dma4_arbiter #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed_w),
    .ready (xfer_ready),
    .valid (xfer_valid),
    .grant (xfer_ch)
  );

  assign xfer_src  = src_w[xfer_ch];
  assign xfer_dst  = dst_w[xfer_ch];
  assign xfer_wide = wide_w[xfer_ch];
  assign xfer_last = last_w[xfer_ch];
  assign cpu_stall = |stall_w;

  // R9
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_ch) && $stable(xfer_src)
                                     && $stable(xfer_dst) && $stable(xfer_wide)
                                     && $stable(xfer_last)));

  // R3
  stall_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> xfer_valid);
endmodule

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_ch = '0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        hblank_pulse = 1'b0;
  logic        vblank_pulse = 1'b0;
  logic        xfer_ready = 1'b1;
  logic        xfer_valid, xfer_wide, xfer_last, cpu_stall;
  logic [1:0]  xfer_ch;
  logic [31:0] xfer_src, xfer_dst;
  logic [3:0]  chan_en;

  int n_checks = 0;
  int n_err = 0;
  int hs_cnt [4];
  logic [31:0] exp_src [4];
  logic [31:0] exp_dst [4];
  int sstep [4];
  int dstep [4];
  bit exp_wide [4];
  int max_ch = 0;
  int order_err = 0;

  always #5 clk = ~clk;

  dma4_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .hblank_pulse(hblank_pulse), .vblank_pulse(vblank_pulse),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_ch(xfer_ch),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_wide(xfer_wide),
    .xfer_last(xfer_last), .cpu_stall(cpu_stall), .chan_en(chan_en)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic end_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  // per-unit address checks (R5, R9)
  always @(negedge clk) begin
    if (rst_n && xfer_valid && xfer_ready) begin
      automatic int c = int'(xfer_ch);
      check(xfer_src == exp_src[c], "R5 src", xfer_src, exp_src[c]);
      check(xfer_dst == exp_dst[c], "R5 dst", xfer_dst, exp_dst[c]);
      check(xfer_wide == exp_wide[c], "R5 wide", xfer_wide, exp_wide[c]);
      exp_src[c] = exp_src[c] + 32'(sstep[c]);
      exp_dst[c] = exp_dst[c] + 32'(dstep[c]);
      hs_cnt[c]++;
      if (c < max_ch) order_err++;
      max_ch = c;
    end
  end

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 2'(ch); reg_sel = 2'(sel); reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] cnt, input logic [31:0] ctl,
                      input int ss, input int ds);
    exp_src[ch] = s; exp_dst[ch] = d; sstep[ch] = ss; dstep[ch] = ds;
    exp_wide[ch] = ctl[7]; hs_cnt[ch] = 0;
    wr(ch, 0, s);
    wr(ch, 1, d);
    wr(ch, 2, cnt);
    wr(ch, 3, ctl);
  endtask

  task automatic pulse(input bit v);
    @(negedge clk);
    if (v) vblank_pulse = 1'b1; else hblank_pulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vblank_pulse = 1'b0; hblank_pulse = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 70000 && xfer_valid; i++) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    end_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      hs_cnt[i] = 0; exp_src[i] = '0; exp_dst[i] = '0;
      sstep[i] = 0; dstep[i] = 0; exp_wide[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(xfer_valid == 0, "R1 valid", xfer_valid, 0);
    check(cpu_stall == 0, "R1 stall", cpu_stall, 0);
    check(chan_en == 0, "R1 chan_en", chan_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(xfer_valid == 0, "R1 valid after release", xfer_valid, 0);

    // R3 immediate start, inc source / dec destination, 4-byte units
    prog(1, 32'h1000, 32'h2000, 5, 161, 4, -4);
    check(cpu_stall == 1, "R3 stall on immediate", cpu_stall, 1);
    check(chan_en[1] == 1, "R3 enable set", chan_en[1], 1);
    wait_idle();
    check(hs_cnt[1] == 5, "R9 unit count", hs_cnt[1], 5);
    check(chan_en[1] == 0, "R7 enable self-clear", chan_en[1], 0);
    check(cpu_stall == 0, "R3 stall drops", cpu_stall, 0);

    // R5 fixed source, reload-code destination, 2-byte units
    prog(2, 32'h300, 32'h500, 3, 113, 0, 2);
    wait_idle();
    check(hs_cnt[2] == 3, "R5 fixed/reload units", hs_cnt[2], 3);

    // R4/R8 blanking timed channels
    prog(0, 32'h8000, 32'h9000, 4, 131, 4, 4);
    prog(2, 32'hA000, 32'hB000, 3, 139, -4, 4);
    check(xfer_valid == 0, "R4 not armed before pulse", xfer_valid, 0);
    pulse(0);
    check(xfer_valid == 0, "R4 hblank ignored by vblank channels", xfer_valid, 0);
    max_ch = 0; order_err = 0;
    pulse(1);
    check(xfer_valid == 1, "R4 vblank arms", xfer_valid, 1);
    check(cpu_stall == 0, "R4 blanking no stall", cpu_stall, 0);
    check(xfer_ch == 0, "R8 channel 0 first", xfer_ch, 0);
    wait_idle();
    check(order_err == 0, "R8 priority order", order_err, 0);
    check(hs_cnt[0] == 4 && hs_cnt[2] == 3, "R8 both complete", hs_cnt[0] * 16 + hs_cnt[2], 67);
    pulse(1);
    check(xfer_valid == 0, "R4 pulse on disabled channel", xfer_valid, 0);

    // R4 special timing never arms; R10 disable
    prog(3, 32'h0, 32'h0, 2, 7, 0, 0);
    pulse(0);
    pulse(1);
    check(xfer_valid == 0, "R4 special never arms", xfer_valid, 0);
    check(chan_en[3] == 1, "R4 special stays enabled", chan_en[3], 1);
    wr(3, 3, 0);
    check(chan_en[3] == 0, "R10 enable cleared", chan_en[3], 0);

    // R10 disable mid-run
    prog(1, 32'h100, 32'h200, 100, 129, 4, 4);
    repeat (10) @(negedge clk);
    wr(1, 3, 0);
    check(xfer_valid == 0, "R10 request stops", xfer_valid, 0);
    check(hs_cnt[1] > 0 && hs_cnt[1] < 100, "R10 partial run", hs_cnt[1], 50);
    repeat (3) @(negedge clk);
    check(xfer_valid == 0, "R10 stays idle", xfer_valid, 0);

    // R9 back-pressure; R2 shadow copies
    xfer_ready = 1'b0;
    prog(1, 32'h4000, 32'h6000, 3, 129, 4, 4);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(xfer_valid == 1 && xfer_src == 32'h4000, "R9 held request", xfer_src, 32'h4000);
    end
    wr(1, 0, 32'h9999);
    wr(1, 2, 0);
    prog(0, 32'h100, 32'h200, 1, 129, 4, 4);
    check(xfer_ch == 1, "R9 grant held under back-pressure", xfer_ch, 1);
    check(xfer_src == 32'h4000, "R2 source unchanged", xfer_src, 32'h4000);
    @(negedge clk);
    xfer_ready = 1'b1;
    wait_idle();
    check(hs_cnt[1] == 3, "R2 count unchanged", hs_cnt[1], 3);
    check(hs_cnt[0] == 1, "R8 channel 0 served", hs_cnt[0], 1);

    // R6 widths and zero count
    prog(0, 32'h0, 32'h10000, 32'h4005, 129, 4, 4);
    wait_idle();
    check(hs_cnt[0] == 5, "R6 14-bit truncation", hs_cnt[0], 5);
    prog(3, 32'h0, 32'h100000, 40000, 129, 4, 4);
    wait_idle();
    check(hs_cnt[3] == 40000, "R6 16-bit count", hs_cnt[3], 40000);
    prog(0, 32'h0, 32'h10000, 0, 129, 4, 4);
    wait_idle();
    check(hs_cnt[0] == 16383, "R6 zero on 14-bit", hs_cnt[0], 16383);
    prog(3, 32'h0, 32'h100000, 0, 129, 4, 4);
    wait_idle();
    check(hs_cnt[3] == 65535, "R6 zero on 16-bit", hs_cnt[3], 65535);
    check(chan_en == 0, "R7 all idle", chan_en, 0);

    end_run();
  end
endmodule